// File: doc/BRIEF.md
# Prescaled Conversion Scheduler

This block decides when a 10-bit analog-to-digital converter starts a conversion. A trimmed 2.5 MHz clock drives it. The sample period is the product of two programmable terms: a prescale divider and a sample counter. Each term takes its programmed value plus one. A product that is too short for one conversion plus a 48-bit serial readout cannot be used. Such a setting is replaced by the shortest legal period, and a sticky configuration error is raised.

The block has two run modes. In continuous mode it issues one start pulse at every period boundary. A boundary that falls while a conversion is still running is skipped. In single-shot mode, software inverts the trigger bit of the control word to ask for one conversion. The converter itself sits outside the block. It answers each start pulse with a done pulse and a 10-bit code after a fixed delay. The block latches that code and presents it on a valid/ready result stream.

The result stream follows these rules. `res_valid` stays high from a capture until the cycle in which `res_ready` is seen high. While valid is high and ready is low, `res_data` holds still. The one exception is a newer conversion that completes before the read: it replaces the code and sets the overrun flag. Software reaches the rate and control words through plain write strobes.

Top module: `conv_sched`

## Requirements
- R1: After reset the block issues no start pulse, `res_valid`, `cfg_err` and `overrun` are low, and the active period is the default (prescale DEF_PS, count DEF_CNT).
- R2: When a control write sets bit 0 to 1, continuous mode is on. The first start pulse appears P clock edges after the write edge, and each following pulse comes P edges after the one before. Here P = (prescale+1)*(count+1).
- R3: In the rate word, the prescale field is the top PS_W bits and the count field is the low CNT_W bits. With the default widths these are bits 15:12 and 11:0.
- R4: A rate write whose product is MIN_PROD or less gives a period of MIN_PROD+1 clocks (prescale 0, count MIN_PROD). It also sets `cfg_err`, which stays high until reset.
- R5: A rate written while continuous mode runs takes effect only at the next period boundary. The period already in progress finishes at its old length.
- R6: A control write with bit 0 at 0 whose top bit (bit 15 by default) differs from the top bit of the previous control write produces exactly one start pulse, visible in the cycle after the write. If the top bit is unchanged, the write produces none.
- R7: A trigger change that arrives while a conversion is in progress (from a start pulse until its done pulse) produces no start pulse.
- R8: A done pulse during a conversion latches `adc_data` into `res_data` and raises `res_valid` on the next edge. A done pulse with no conversion in progress changes neither output.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid` and `res_data` hold. The edge on which both are high drops `res_valid`.
- R10: A conversion that completes while `res_valid` is high and unread sets the sticky `overrun` flag and replaces `res_data` with the newer code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock (trimmed 2.5 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_wr | input | 1 | Write strobe for the rate word |
| rate_wdata | input | PS_W+CNT_W | Rate word: prescale in the upper field, count in the lower |
| start_wr | input | 1 | Write strobe for the control word |
| start_wdata | input | START_W | Control word: bit 0 continuous enable, top bit single-shot trigger |
| adc_start | output | 1 | One-cycle conversion start pulse |
| adc_done | input | 1 | Converter completion pulse |
| adc_data | input | RES_W | Converter output code |
| res_valid | output | 1 | Result stream valid (data ready) |
| res_ready | input | 1 | Result stream ready (result read) |
| res_data | output | RES_W | Latched conversion code |
| cfg_err | output | 1 | Sticky flag: an over-short period was clamped |
| overrun | output | 1 | Sticky flag: an unread result was overwritten |

## Verification
The bench builds the block with a 2-bit prescale and a 5-bit count, a minimum product of 6, and a default of prescale 1, count 9. With these values every one of the 128 rate settings can be swept. Each sweep step measures both the delay to the first start pulse and the spacing to the next one, so the clamp boundary and the field split are both covered. The same short periods make a mid-period rate change and the default period quick to observe. Manual done pulses, issued while conversions are idle or in progress, exercise the trigger, busy, hold and overrun cases.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic {
    MODE_SHOT = 1'b0,
    MODE_CONT = 1'b1
  } run_mode_e;

endpackage

// File: rtl/sched_rate_cfg.sv
module sched_rate_cfg #(
  parameter int PS_W     = 4,
  parameter int CNT_W    = 12,
  parameter int MIN_PROD = 100,
  parameter int DEF_PS   = 3,
  parameter int DEF_CNT  = 2499
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_i,
  input  logic [PS_W+CNT_W-1:0]   wdata_i,
  output logic [PS_W-1:0]         pend_ps_o,
  output logic [CNT_W-1:0]        pend_cnt_o,
  output logic                    cfg_err_o
);
  localparam int PW = PS_W + CNT_W + 1;
  localparam logic [PW-1:0] MIN_P = PW'(MIN_PROD);

  logic [PS_W-1:0]  w_ps;
  logic [CNT_W-1:0] w_cnt;
  logic [PW-1:0]    w_prod;
  logic             w_legal;

  // Field split: prescale on top, count below.
  assign w_ps   = wdata_i[PS_W+CNT_W-1:CNT_W];
  assign w_cnt  = wdata_i[CNT_W-1:0];
  assign w_prod = (PW'(w_ps) + PW'(1)) * (PW'(w_cnt) + PW'(1));
  assign w_legal = (w_prod > MIN_P);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_ps_o  <= PS_W'(DEF_PS);
      pend_cnt_o <= CNT_W'(DEF_CNT);
      cfg_err_o  <= 1'b0;
    end else if (wr_i) begin
      if (w_legal) begin
        pend_ps_o  <= w_ps;
        pend_cnt_o <= w_cnt;
      end else begin
        pend_ps_o  <= '0;
        pend_cnt_o <= CNT_W'(MIN_PROD);
        cfg_err_o  <= 1'b1;
      end
    end
  end

  logic [PW-1:0] pend_prod;
  assign pend_prod = (PW'(pend_ps_o) + PW'(1)) * (PW'(pend_cnt_o) + PW'(1));

  // R4: the stored period is always longer than the minimum
  p_min_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_prod > MIN_P);

  // R4: an illegal write raises the sticky error
  p_err_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !w_legal) |=> cfg_err_o);

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |=> cfg_err_o);

endmodule

// File: rtl/sched_period_gen.sv
module sched_period_gen #(
  parameter int PS_W    = 4,
  parameter int CNT_W   = 12,
  parameter int DEF_PS  = 3,
  parameter int DEF_CNT = 2499
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [PS_W-1:0]  pend_ps_i,
  input  logic [CNT_W-1:0] pend_cnt_i,
  output logic             tick_o
);
  logic [PS_W-1:0]  lim_ps;
  logic [CNT_W-1:0] lim_cnt;
  logic [PS_W-1:0]  ps_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ps_wrap;
  logic             cnt_last;

  assign ps_wrap  = (ps_q == lim_ps);
  assign cnt_last = (cnt_q == lim_cnt);
  assign tick_o   = run_i && ps_wrap && cnt_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_ps  <= PS_W'(DEF_PS);
      lim_cnt <= CNT_W'(DEF_CNT);
      ps_q    <= '0;
      cnt_q   <= '0;
    end else if (!run_i) begin
      // Idle: counters parked, limits follow the pending setting.
      ps_q    <= '0;
      cnt_q   <= '0;
      lim_ps  <= pend_ps_i;
      lim_cnt <= pend_cnt_i;
    end else if (ps_wrap) begin
      ps_q <= '0;
      if (cnt_last) begin
        cnt_q   <= '0;
        lim_ps  <= pend_ps_i;
        lim_cnt <= pend_cnt_i;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end else begin
      ps_q <= ps_q + PS_W'(1);
    end
  end

  // R5: limits never change inside a running period
  p_hold_limits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_o) |=> ($stable(lim_ps) && $stable(lim_cnt)));

  // R2: a stopped generator restarts from a fresh period
  p_park_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (ps_q == '0 && cnt_q == '0));

endmodule

// File: rtl/sched_conv_ctrl.sv
module sched_conv_ctrl #(
  parameter int DUMMY = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic cont_bit_i,
  input  logic trig_bit_i,
  input  logic tick_i,
  input  logic adc_done_i,
  output logic run_o,
  output logic adc_start_o,
  output logic busy_o
);
  import sched_pkg::*;

  run_mode_e mode_q;
  logic      trig_q;
  logic      start_q;
  logic      busy_q;
  logic      shot;
  logic      fire;

  assign shot = wr_i && (trig_bit_i != trig_q) && !cont_bit_i && !busy_q;
  assign fire = (shot || tick_i) && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_SHOT;
      trig_q  <= 1'b0;
      start_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      if (wr_i) begin
        mode_q <= cont_bit_i ? MODE_CONT : MODE_SHOT;
        trig_q <= trig_bit_i;
      end
      start_q <= fire;
      if (fire)            busy_q <= 1'b1;
      else if (adc_done_i) busy_q <= 1'b0;
    end
  end

  assign run_o       = (mode_q == MODE_CONT);
  assign adc_start_o = start_q;
  assign busy_o      = busy_q;

  // R7: no new start while a conversion is outstanding
  p_no_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !adc_done_i) |=> !adc_start_o);

  // R6: every start is a single-cycle pulse
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start_o |=> !adc_start_o);

endmodule

// File: rtl/sched_result_buf.sv
module sched_result_buf #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic             busy_i,
  input  logic [RES_W-1:0] data_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [RES_W-1:0] data_o,
  output logic             overrun_o
);
  logic cap;
  logic take;

  assign cap  = done_i && busy_i;
  assign take = valid_o && ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      data_o    <= '0;
      overrun_o <= 1'b0;
    end else begin
      if (cap) begin
        valid_o <= 1'b1;
        data_o  <= data_i;
        if (valid_o && !ready_i) overrun_o <= 1'b1;
      end else if (take) begin
        valid_o <= 1'b0;
      end
    end
  end

  // R9: held result stays put until read
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && !cap) |=> (valid_o && $stable(data_o)));

  // R9: a read drains the stream
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cap) |=> !valid_o);

  // R10: overwrite of an unread result flags overrun
  p_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && valid_o && !ready_i) |=> overrun_o);

  // R8: a stray done pulse leaves the stream alone
  p_stray_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !busy_i && !valid_o) |=> !valid_o);

endmodule

// File: rtl/conv_sched.sv
module conv_sched #(
  parameter int PS_W     = 4,
  parameter int CNT_W    = 12,
  parameter int RES_W    = 10,
  parameter int START_W  = 16,
  parameter int MIN_PROD = 100,
  parameter int DEF_PS   = 3,
  parameter int DEF_CNT  = 2499
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rate_wr,
  input  logic [PS_W+CNT_W-1:0]  rate_wdata,
  input  logic                   start_wr,
  input  logic [START_W-1:0]     start_wdata,
  output logic                   adc_start,
  input  logic                   adc_done,
  input  logic [RES_W-1:0]       adc_data,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic [RES_W-1:0]       res_data,
  output logic                   cfg_err,
  output logic                   overrun
);
  localparam int TRIG_BIT = START_W - 1;

  logic [PS_W-1:0]  pend_ps;
  logic [CNT_W-1:0] pend_cnt;
  logic             run;
  logic             tick;
  logic             busy;
  logic             unused_mid;

  assign unused_mid = ^start_wdata[TRIG_BIT-1:1];

  sched_rate_cfg #(
    .PS_W(PS_W), .CNT_W(CNT_W), .MIN_PROD(MIN_PROD),
    .DEF_PS(DEF_PS), .DEF_CNT(DEF_CNT)
  ) u_rate (
    .clk(clk), .rst_n(rst_n), .wr_i(rate_wr), .wdata_i(rate_wdata),
    .pend_ps_o(pend_ps), .pend_cnt_o(pend_cnt), .cfg_err_o(cfg_err)
  );

  sched_period_gen #(
    .PS_W(PS_W), .CNT_W(CNT_W), .DEF_PS(DEF_PS), .DEF_CNT(DEF_CNT)
  ) u_period (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .pend_ps_i(pend_ps), .pend_cnt_i(pend_cnt), .tick_o(tick)
  );

  sched_conv_ctrl #(.DUMMY(0)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(start_wr),
    .cont_bit_i(start_wdata[0]), .trig_bit_i(start_wdata[TRIG_BIT]),
    .tick_i(tick), .adc_done_i(adc_done),
    .run_o(run), .adc_start_o(adc_start), .busy_o(busy)
  );

  sched_result_buf #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst_n(rst_n), .done_i(adc_done), .busy_i(busy),
    .data_i(adc_data), .ready_i(res_ready),
    .valid_o(res_valid), .data_o(res_data), .overrun_o(overrun)
  );

  // R1: flags are quiet out of reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!adc_start && !res_valid && !cfg_err && !overrun));

endmodule

// File: tb/conv_sched_bench.sv
`timescale 1ns/1ps
module conv_sched_bench;
  localparam int PS_W = 2, CNT_W = 5, RES_W = 10, START_W = 16;
  localparam int MIN_PROD = 6, DEF_PS = 1, DEF_CNT = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_wr = 1'b0;
  logic [PS_W+CNT_W-1:0] rate_wdata = '0;
  logic start_wr = 1'b0;
  logic [START_W-1:0] start_wdata = '0;
  logic adc_start;
  logic adc_done;
  logic [RES_W-1:0] adc_data;
  logic res_valid;
  logic res_ready = 1'b0;
  logic [RES_W-1:0] res_data;
  logic cfg_err, overrun;

  logic auto_en = 1'b1, auto_done = 1'b0, man_done = 1'b0;
  logic [RES_W-1:0] auto_data = '0, man_data = '0;
  assign adc_done = auto_done | man_done;
  assign adc_data = auto_en ? auto_data : man_data;

  conv_sched #(.PS_W(PS_W), .CNT_W(CNT_W), .RES_W(RES_W), .START_W(START_W),
    .MIN_PROD(MIN_PROD), .DEF_PS(DEF_PS), .DEF_CNT(DEF_CNT)) u_conv_sched (
    .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_wdata(rate_wdata),
    .start_wr(start_wr), .start_wdata(start_wdata), .adc_start(adc_start),
    .adc_done(adc_done), .adc_data(adc_data), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .cfg_err(cfg_err),
    .overrun(overrun));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_starts = 0, t_prev = 0, t_last = 0, cd = 0;
  int errors = 0, checks = 0, ew = 0;
  logic tog = 1'b0;
  logic finished = 1'b0;

  // Start monitor and fixed-latency converter model.
  always @(negedge clk) begin
    auto_done = 1'b0;
    if (cd != 0) begin
      cd = cd - 1;
      if (cd == 0) begin
        auto_done = auto_en;
        auto_data = auto_data + 10'd3;
      end
    end
    if (adc_start === 1'b1) begin
      n_starts = n_starts + 1;
      t_prev = t_last;
      t_last = cyc;
      if (auto_en) cd = 4;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_rate(input int ps, input int cnt);
    @(negedge clk);
    rate_wr = 1'b1;
    rate_wdata = {PS_W'(ps), CNT_W'(cnt)};
    @(negedge clk);
    rate_wr = 1'b0;
  endtask

  task automatic wr_ctrl(input logic trig, input logic cont);
    @(negedge clk);
    start_wr = 1'b1;
    start_wdata = '0;
    start_wdata[START_W-1] = trig;
    start_wdata[0] = cont;
    @(negedge clk);
    start_wr = 1'b0;
    ew = cyc;
  endtask

  task automatic man_pulse(input logic [RES_W-1:0] d);
    @(negedge clk);
    man_done = 1'b1;
    man_data = d;
    @(negedge clk);
    man_done = 1'b0;
  endtask

  task automatic rd_result();
    @(negedge clk);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic wait_starts(input int target);
    for (int i = 0; i < 600 && n_starts < target; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    tog = 1'b0;
    cd = 0;
  endtask

  initial begin
    int base, s, p, prod;
    do_reset();
    idle(2);
    // R1: reset state
    check(adc_start == 1'b0, "R1 start", adc_start, 0);
    check(res_valid == 1'b0, "R1 valid", res_valid, 0);
    check(cfg_err == 1'b0 && overrun == 1'b0, "R1 flags", {cfg_err, overrun}, 0);
    idle(10);
    check(n_starts == 0, "R1 no start", n_starts, 0);

    // R1/R2: default period in continuous mode
    base = n_starts;
    wr_ctrl(tog, 1'b1);
    wait_starts(base + 2);
    check(t_prev - ew == 20, "R1 default first", t_prev - ew, 20);
    check(t_last - t_prev == 20, "R2 default spacing", t_last - t_prev, 20);

    // R5: mid-period rate change waits for the boundary
    base = n_starts;
    wait_starts(base + 1);
    s = t_last;
    idle(3);
    wr_rate(0, 9);
    wait_starts(base + 3);
    check(t_prev - s == 20, "R5 old period kept", t_prev - s, 20);
    check(t_last - t_prev == 10, "R5 new period", t_last - t_prev, 10);
    check(cfg_err == 1'b0, "R4 no error on legal", cfg_err, 0);

    // R2/R3/R4: sweep every rate setting
    for (int ps = 0; ps < 4; ps++) begin
      for (int cnt = 0; cnt < 32; cnt++) begin
        wr_ctrl(tog, 1'b0);
        idle(8);
        wr_rate(ps, cnt);
        idle(2);
        prod = (ps + 1) * (cnt + 1);
        p = (prod > MIN_PROD) ? prod : MIN_PROD + 1;
        base = n_starts;
        wr_ctrl(tog, 1'b1);
        wait_starts(base + 2);
        if (prod > MIN_PROD) begin
          check(t_prev - ew == p, "R2 first start", t_prev - ew, p);
          check(t_last - t_prev == p, "R3 field split", t_last - t_prev, p);
        end else begin
          check(t_prev - ew == p, "R4 clamp first", t_prev - ew, p);
          check(t_last - t_prev == p, "R4 clamp spacing", t_last - t_prev, p);
        end
      end
    end
    check(cfg_err == 1'b1, "R4 sticky error", cfg_err, 1);
    wr_rate(3, 31);
    idle(2);
    check(cfg_err == 1'b1, "R4 still set", cfg_err, 1);

    // Single-shot and result stream with manual converter
    wr_ctrl(tog, 1'b0);
    idle(10);
    auto_en = 1'b0;
    do_reset();
    idle(2);
    base = n_starts;
    tog = ~tog;
    wr_ctrl(tog, 1'b0);
    idle(1);
    check(n_starts == base + 1 && t_last == ew, "R6 toggle start", t_last - ew, 0);
    tog = ~tog;
    wr_ctrl(tog, 1'b0);
    idle(4);
    check(n_starts == base + 1, "R7 toggle while busy", n_starts - base, 1);
    man_pulse(10'h2A5);
    check(res_valid == 1'b1 && res_data == 10'h2A5, "R8 capture", res_data, 10'h2A5);
    check(overrun == 1'b0, "R10 no overrun yet", overrun, 0);
    idle(4);
    check(res_valid == 1'b1 && res_data == 10'h2A5, "R9 hold", res_data, 10'h2A5);
    wr_ctrl(tog, 1'b0);
    idle(4);
    check(n_starts == base + 1, "R6 no toggle no start", n_starts - base, 1);
    rd_result();
    check(res_valid == 1'b0, "R9 drain", res_valid, 0);
    man_pulse(10'h0F0);
    check(res_valid == 1'b0 && res_data == 10'h2A5, "R8 stray done", res_data, 10'h2A5);

    tog = ~tog;
    wr_ctrl(tog, 1'b0);
    man_pulse(10'h155);
    tog = ~tog;
    wr_ctrl(tog, 1'b0);
    man_pulse(10'h3FF);
    check(n_starts == base + 3, "R6 two shots", n_starts - base, 3);
    check(overrun == 1'b1, "R10 overrun set", overrun, 1);
    check(res_data == 10'h3FF, "R10 newest kept", res_data, 10'h3FF);
    rd_result();
    check(res_valid == 1'b0 && overrun == 1'b1, "R10 sticky", overrun, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule